// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Line Errors

This block sits between a serial deserializer and the register file of a 16550-style UART. Every received character enters a 16-deep queue along with three line-error flags (parity, framing, break). Each flag stays with its own character until software reads that character. From the queue contents the block builds the line status byte. It also raises a fill-level trigger for the received-data interrupt and a character-timeout flag for the case where a few characters sit below the trigger level.

Software reads the head character through `rbr_data` and pulses `rbr_rd` to remove it. It reads the status byte through `lsr` and pulses `lsr_rd` to acknowledge sticky conditions. A write to the FIFO control register (`fcr_we`, `fcr_wdata`) can flush the queue, request a flush of the transmit side, and select the trigger level.

Top module: `uart_rxq_top`

## Requirements
- R1: After reset the queue is empty. `lsr` reads `{1'b0, tx_idle, thr_empty, 5'b0}` (0x60 when both transmit flags are high). `rbr_data` is 0x00, and `trig_hit` and `timeout` are low.
- R2: Characters leave in arrival order. `rbr_data` shows the head character while `lsr[0]` is 1, and `lsr[0]` is 1 exactly while the queue holds at least one entry.
- R3: The queue holds at most 16 entries. A character arriving while 16 are held and no read happens is dropped. It sets `lsr[1]` and `lsr[7]` (0xE3 with 16 clean entries and an idle transmitter). An `lsr_rd` clears the overrun from the next cycle (0x61), and the held entries are untouched.
- R4: A break stores the character 0x00 with its break flag. At the head it sets `lsr[4]` and `lsr[7]` (0xF1). An `lsr_rd` hides that head's flags and their part of `lsr[7]` (0x61) until the entry is read.
- R5: `lsr[2]` (parity) and `lsr[3]` (framing) show the flags of the head entry. A framing error at the head reads 0xE9, and a parity error reads 0xE5.
- R6: `lsr[7]` stays 1 while any unacknowledged flagged entry is held, even when the flagged entry is not at the head.
- R7: `rbr_rd` while the queue is empty has no effect. The queue stays empty, `lsr` stays 0x60 and `rbr_data` stays 0x00.
- R8: An FCR write with bit 1 set empties the queue, and a character arriving in the same cycle is discarded. Bit 2 drives `tx_clr` high in the write cycle only and leaves the receive queue unchanged. `lsr[5]` and `lsr[6]` follow `thr_empty` and `tx_idle`, so an empty queue with a busy shifter reads 0x20.
- R9: FCR bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `trig_hit` is 1 while the entry count is at or above the level.
- R10: `timeout` rises once four `char_tick` pulses have passed with the queue non-empty and no push, read or flush. It requires the count to be below the trigger level. An `rbr_rd` clears it.
- R11: A character arriving in the same cycle as an `rbr_rd` on a full queue is accepted without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Deserializer presents a character this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error on the received character |
| rx_ferr | input | 1 | Framing error on the received character |
| rx_brk | input | 1 | Break condition received |
| fcr_we | input | 1 | FIFO control register write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| rbr_rd | input | 1 | Receive buffer read pulse |
| lsr_rd | input | 1 | Line status read pulse |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_idle | input | 1 | Transmit holding and shift registers empty |
| char_tick | input | 1 | One pulse per character time |
| rbr_data | output | 8 | Head character, 0x00 when empty |
| lsr | output | 8 | Line status byte |
| trig_hit | output | 1 | Entry count at or above trigger level |
| timeout | output | 1 | Character-timeout indication |
| tx_clr | output | 1 | Transmit queue flush request |

## Verification
Directed sequences cover the exact status codes:
- filling to 16 and overrunning, then acknowledging;
- a break character, a framing error and a parity error at the head;
- a flagged character waiting behind a clean one, which separates the whole-queue error summary from the head-only flag bits;
- a read on an empty queue, flushes that collide with an arriving character, and a full queue read and written in the same cycle.

Every trigger level is stepped across its boundary, and the timeout is counted tick by tick. A seeded random mix of pushes, reads, status reads, flushes and ticks then runs against a queue model in the bench. That model exposes ordering or acknowledge-masking mistakes that the fixed patterns do not reach.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rxq_ent_t;

  // trigger level selected by the two high FCR bits
  function automatic logic [3:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      2'd2:    return 4'd8;
      default: return 4'd14;
    endcase
  endfunction

  function automatic logic ent_has_err(input rxq_ent_t e);
    return e.brk | e.ferr | e.perr;
  endfunction

  // character stored for an incoming beat: a break always stores zero
  function automatic rxq_ent_t make_ent(input logic [7:0] d, input logic pe,
                                        input logic fe, input logic bk);
    rxq_ent_t e;
    e.brk  = bk;
    e.ferr = fe;
    e.perr = pe;
    e.data = bk ? 8'h00 : d;
    return e;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  rxq_ent_t      push_ent,
  input  logic          pop,
  output rxq_ent_t      head_ent,
  output logic [CW-1:0] count,
  output logic [CW-1:0] err_cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rxq_ent_t      mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_err, pop_err;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign head_ent = mem[rd_ptr];
  assign push_err = push & ent_has_err(push_ent);
  assign pop_err  = pop & ent_has_err(head_ent);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      case ({push_err, pop_err})
        2'b10:   err_cnt <= err_cnt + 1'b1;
        2'b01:   err_cnt <= err_cnt - 1'b1;
        default: err_cnt <= err_cnt;
      endcase
    end
  end
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pop,
  input  logic          lsr_rd,
  input  logic          ovr_evt,
  input  logic          nonempty,
  input  rxq_ent_t      head_ent,
  input  logic [CW-1:0] err_cnt,
  input  logic          thr_empty,
  input  logic          tx_idle,
  output logic [7:0]    lsr
);
  logic       ovr_q, head_ack_q;
  logic       head_err;
  logic [2:0] head_flags;

  // flagged entries still unacknowledged, anywhere in the queue
  function automatic logic errs_left(input logic [CW-1:0] n, input logic herr,
                                     input logic ack);
    logic [CW-1:0] hidden;
    hidden = (herr && ack) ? CW'(1) : '0;
    return (n - hidden) != '0;
  endfunction

  assign head_err   = nonempty & ent_has_err(head_ent);
  assign head_flags = (nonempty && !head_ack_q) ?
                      {head_ent.brk, head_ent.ferr, head_ent.perr} : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q      <= 1'b0;
      head_ack_q <= 1'b0;
    end else begin
      if (ovr_evt)     ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;
      if (clr || pop)              head_ack_q <= 1'b0;
      else if (lsr_rd && nonempty) head_ack_q <= 1'b1;
    end
  end

  assign lsr = {ovr_q | errs_left(err_cnt, head_err, head_ack_q),
                tx_idle, thr_empty, head_flags, ovr_q, nonempty};
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TO_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  input  logic tick,
  input  logic nonempty,
  output logic expired
);
  localparam int TW = $clog2(TO_CHARS + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TO_CHARS);

  logic [TW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    idle_cnt <= '0;
    else if (activity)                             idle_cnt <= '0;
    else if (tick && nonempty && idle_cnt < LIMIT) idle_cnt <= idle_cnt + 1'b1;
  end

  assign expired = (idle_cnt == LIMIT);
endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       fcr_we,
  input  logic [7:0] fcr_wdata,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  input  logic       thr_empty,
  input  logic       tx_idle,
  input  logic       char_tick,
  output logic [7:0] rbr_data,
  output logic [7:0] lsr,
  output logic       trig_hit,
  output logic       timeout,
  output logic       tx_clr
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rxq_ent_t      head_ent;
  logic [CW-1:0] rx_count, err_cnt;
  logic [1:0]    trig_sel;
  logic          nonempty, clr_rx, pop_ok, push_ok, ovr_evt, idle_exp;
  logic [CW-1:0] trig_cnt;

  // named events, used by the logic and by the bound checker
  assign nonempty = (rx_count != '0);
  assign clr_rx   = fcr_we & fcr_wdata[1];
  assign pop_ok   = rbr_rd & nonempty & ~clr_rx;
  assign push_ok  = rx_valid & ~clr_rx & ((rx_count != FULL_CNT) | pop_ok);
  assign ovr_evt  = rx_valid & ~clr_rx & (rx_count == FULL_CNT) & ~pop_ok;
  assign tx_clr   = fcr_we & fcr_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trig_sel <= 2'd0;
    else if (fcr_we) trig_sel <= fcr_wdata[7:6];
  end

  assign trig_cnt = CW'(trig_level(trig_sel));
  assign trig_hit = (rx_count >= trig_cnt);
  assign timeout  = idle_exp & nonempty & ~trig_hit;
  assign rbr_data = nonempty ? head_ent.data : 8'h00;

  rxq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr_rx), .push(push_ok),
    .push_ent(make_ent(rx_data, rx_perr, rx_ferr, rx_brk)),
    .pop(pop_ok), .head_ent(head_ent), .count(rx_count), .err_cnt(err_cnt)
  );

  rxq_status #(.CW(CW)) u_status (
    .clk(clk), .rst_n(rst_n), .clr(clr_rx), .pop(pop_ok), .lsr_rd(lsr_rd),
    .ovr_evt(ovr_evt), .nonempty(nonempty), .head_ent(head_ent),
    .err_cnt(err_cnt), .thr_empty(thr_empty), .tx_idle(tx_idle), .lsr(lsr)
  );

  rxq_idle_timer #(.TO_CHARS(TO_CHARS)) u_timer (
    .clk(clk), .rst_n(rst_n), .activity(push_ok | pop_ok | clr_rx),
    .tick(char_tick), .nonempty(nonempty), .expired(idle_exp)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rbr_rd,
  input logic          lsr_rd,
  input logic          clr_rx,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          ovr_evt,
  input logic [CW-1:0] count,
  input logic [7:0]    lsr,
  input logic [7:0]    rbr_data,
  input logic          trig_hit,
  input logic          timeout
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  p_ovr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && count == FULL_CNT && !pop_ok && !clr_rx) |=> lsr[1]);

  p_ovr_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_evt) |=> !lsr[1]);

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> count == $past(count) + 1'b1);

  p_break_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[4] |-> rbr_data == 8'h00);

  p_err_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|lsr[4:2]) |-> lsr[7]);

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && count == '0 && !rx_valid) |=> count == '0);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rx |=> count == '0);

  p_timeout_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (lsr[0] && !trig_hit));
endmodule

bind uart_rxq_top rxq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rbr_rd(rbr_rd),
  .lsr_rd(lsr_rd), .clr_rx(clr_rx), .push_ok(push_ok), .pop_ok(pop_ok),
  .ovr_evt(ovr_evt), .count(rx_count), .lsr(lsr), .rbr_data(rbr_data),
  .trig_hit(trig_hit), .timeout(timeout)
);

// File: tb/tb_uart_rxq_top.sv
module tb_uart_rxq_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int TO    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic [7:0] rx_data = 0, fcr_wdata = 0;
  logic fcr_we = 0, rbr_rd = 0, lsr_rd = 0, char_tick = 0;
  logic thr_empty = 1, tx_idle = 1;
  logic [7:0] rbr_data, lsr;
  logic trig_hit, timeout, tx_clr;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // bench model
  bit [10:0] mq[$];
  bit m_ovr = 0, m_ack = 0, txc_seen = 0;
  bit [1:0] m_sel = 0;
  int m_idle = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_rxq_top dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .fcr_we(fcr_we),
    .fcr_wdata(fcr_wdata), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
    .thr_empty(thr_empty), .tx_idle(tx_idle), .char_tick(char_tick),
    .rbr_data(rbr_data), .lsr(lsr), .trig_hit(trig_hit), .timeout(timeout),
    .tx_clr(tx_clr)
  );

  function automatic int lvl(input bit [1:0] s);
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  function automatic bit [7:0] exp_lsr();
    bit [2:0] hf, vis; int errs = 0;
    hf = (mq.size() > 0) ? mq[0][10:8] : 3'b0;
    vis = m_ack ? 3'b0 : hf;
    foreach (mq[i]) if (mq[i][10:8] != 0) errs++;
    if (m_ack && hf != 0) errs--;
    return {m_ovr | (errs != 0), tx_idle, thr_empty, vis, m_ovr, mq.size() > 0};
  endfunction

  function automatic bit [7:0] exp_rbr();
    return (mq.size() > 0) ? mq[0][7:0] : 8'h00;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "lsr", lsr, exp_lsr());
    chk(req, "rbr_data", rbr_data, exp_rbr());
    chk(req, "trig_hit", trig_hit, mq.size() >= lvl(m_sel));
    chk(req, "timeout", timeout,
        m_idle == TO && mq.size() > 0 && mq.size() < lvl(m_sel));
  endtask

  // one clock with the current drive; model follows the requirements
  task automatic step();
    int sz; bit clr, pop, pu, ov;
    #1 txc_seen = tx_clr;
    sz  = mq.size();
    clr = fcr_we && fcr_wdata[1];
    pop = rbr_rd && sz > 0 && !clr;
    pu  = rx_valid && !clr && (sz < DEPTH || pop);
    ov  = rx_valid && !clr && sz == DEPTH && !pop;
    @(posedge clk);
    if (clr) begin mq.delete(); m_ack = 0; end
    else begin
      if (pop) begin void'(mq.pop_front()); m_ack = 0; end
      else if (lsr_rd && sz > 0) m_ack = 1;
      if (pu) mq.push_back({rx_brk, rx_ferr, rx_perr, rx_brk ? 8'h00 : rx_data});
    end
    if (ov) m_ovr = 1; else if (lsr_rd) m_ovr = 0;
    if (fcr_we) m_sel = fcr_wdata[7:6];
    if (clr || pu || pop) m_idle = 0;
    else if (char_tick && sz > 0 && m_idle < TO) m_idle++;
    #1;
    rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    fcr_we = 0; rbr_rd = 0; lsr_rd = 0; char_tick = 0;
    #1;
  endtask

  task automatic push(input bit [7:0] d, input bit pe = 0, input bit fe = 0,
                      input bit bk = 0);
    rx_valid = 1; rx_data = d; rx_perr = pe; rx_ferr = fe; rx_brk = bk; step();
  endtask
  task automatic rd();  rbr_rd = 1; step(); endtask
  task automatic lrd(); lsr_rd = 1; step(); endtask
  task automatic fcr(input bit [7:0] v); fcr_we = 1; fcr_wdata = v; step(); endtask
  task automatic tick(); char_tick = 1; step(); endtask
  task automatic drain(input string req);
    while (mq.size() > 0) begin check_all(req); rd(); end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #2;

    // R1 reset state
    chk("R1", "lsr", lsr, 8'h60);
    check_all("R1");

    // R7 empty read
    rd();
    chk("R7", "lsr", lsr, 8'h60);
    chk("R7", "rbr_data", rbr_data, 8'h00);
    push(8'h41);
    chk("R7", "rbr after empty read", rbr_data, 8'h41);
    drain("R7");

    // R3 / R11 fill, overrun, acknowledge
    for (int i = 0; i < DEPTH; i++) push(8'h30 + 8'(i));
    check_all("R3");
    push(8'hEE);
    chk("R3", "lsr overrun", lsr, 8'hE3);
    lrd();
    chk("R3", "lsr after ack", lsr, 8'h61);
    chk("R3", "head kept", rbr_data, 8'h30);
    rx_valid = 1; rx_data = 8'h99; rbr_rd = 1; step();
    chk("R11", "lsr no overrun", lsr, 8'h61);
    chk("R11", "next head", rbr_data, 8'h31);
    drain("R2");

    // R4 break
    push(8'h5A, 0, 0, 1);
    chk("R4", "lsr break", lsr, 8'hF1);
    chk("R4", "break data", rbr_data, 8'h00);
    lrd();
    chk("R4", "lsr after ack", lsr, 8'h61);
    rd();
    chk("R4", "lsr after read", lsr, 8'h60);

    // R5 framing and parity at head
    push(8'h63, 0, 1, 0);
    chk("R5", "lsr framing", lsr, 8'hE9);
    rd();
    push(8'h64, 1, 0, 0);
    chk("R5", "lsr parity", lsr, 8'hE5);
    rd();

    // R6 flagged entry behind a clean one
    push(8'h11); push(8'h22, 1, 0, 0);
    chk("R6", "lsr summary", lsr, 8'hE1);
    lrd();
    chk("R6", "summary after ack", lsr, 8'hE1);
    rd();
    chk("R6", "head flagged", lsr, 8'hE5);
    rd();

    // R8 flushes and transmit flags
    push(8'h01); push(8'h02); push(8'h03);
    fcr_we = 1; fcr_wdata = 8'h02; rx_valid = 1; rx_data = 8'h04; step();
    chk("R8", "lsr after flush", lsr, 8'h60);
    push(8'h07);
    fcr(8'h04);
    chk("R8", "tx_clr pulse", txc_seen, 1);
    chk("R8", "tx_clr low after", tx_clr, 0);
    chk("R8", "rx kept", rbr_data, 8'h07);
    rd();
    tx_idle = 0;
    #1 chk("R8", "lsr busy shifter", lsr, 8'h20);
    tx_idle = 1; #1;

    // R9 trigger levels
    for (int s = 0; s < 4; s++) begin
      fcr({2'(s), 6'b0});
      for (int k = 1; k < lvl(2'(s)); k++) push(8'(k));
      chk("R9", "below level", trig_hit, 0);
      push(8'hAA);
      chk("R9", "at level", trig_hit, 1);
      fcr({2'(s), 6'b000010});
    end

    // R10 timeout
    fcr(8'h80);
    push(8'h54);
    repeat (3) tick();
    chk("R10", "no timeout at 3", timeout, 0);
    tick();
    chk("R10", "timeout at 4", timeout, 1);
    rd();
    chk("R10", "cleared by read", timeout, 0);
    fcr(8'h00);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      rx_valid  = ($urandom % 10) < 4;
      rx_data   = 8'($urandom);
      rx_perr   = ($urandom % 16) == 0;
      rx_ferr   = ($urandom % 16) == 0;
      rx_brk    = ($urandom % 24) == 0;
      rbr_rd    = ($urandom % 10) < 3;
      lsr_rd    = ($urandom % 10) == 0;
      char_tick = ($urandom % 10) < 4;
      fcr_we    = ($urandom % 40) == 0;
      fcr_wdata = {2'($urandom), 3'b0, 1'b0, ($urandom % 3) == 0, 1'b1};
      step();
      check_all("R2");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule